// File: doc/BRIEF.md
# Message-Signaled Interrupt Aggregation Controller

This block collects inbound message-signaled interrupt writes that target one fixed 64-bit doorbell address. The message data names the vector, from 0 to 255. Each accepted message latches a pending bit for its vector. The block drives one level-sensitive summary interrupt while any pending vector is also enabled.

Software uses a small 32-bit register port. Pending bits sit in a bank of eight words at byte offsets 0x80 to 0x9C. Writing ones to a pending word clears those bits. Per-vector enable bits sit in a second bank of eight plain read/write words at byte offsets 0xA0 to 0xBC. Vector n lives in word n/32, at byte offset base + 4*(n/32), bit n%32, in both banks.

An interrupt handler reads the pending words to find its sources and then clears them. Masking or unmasking a single vector is a read-modify-write of one enable word.

Top module: `msi_agg_ctrl`

## Requirements
- R1: After reset every pending and enable bit is zero, irq_o is low and reg_rdata_o is zero.
- R2: A message with msg_valid_i high, msg_addr_i equal to the doorbell address (default 64'h0000_0040_F000_0100) and msg_data_i below 256 sets pending bit msg_data_i%32 of pending word msg_data_i/32 at the next clock edge. This happens whether or not the vector is enabled.
- R3: A message whose address differs from the doorbell in any bit, or whose data is 256 or more, changes no pending bit.
- R4: A register write to pending word w (offset 0x80+4w) clears exactly the bits that are one in reg_wdata_i and leaves the other bits of that word and of every other word unchanged.
- R5: A register write to enable word w (offset 0xA0+4w) replaces all 32 bits of that word, and reading the word returns what was written. Writes to either bank never alter the other bank.
- R6: irq_o is high exactly when some vector is both pending and enabled. It follows the register state updated at the previous clock edge, so a set, clear or enable change shows on irq_o one cycle after the input that caused it.
- R7: When an accepted message and a pending-word clear hit the same bit in the same cycle, the bit ends up set.
- R8: When reg_re_i is high in a cycle, reg_rdata_o carries the addressed word's value in the next cycle. In a cycle that follows one with reg_re_i low, reg_rdata_o is zero.
- R9: Offsets outside both banks, including offsets that are not a multiple of 4, read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| msg_valid_i | input | 1 | Inbound message write strobe |
| msg_addr_i | input | 64 | Inbound message target address |
| msg_data_i | input | 32 | Inbound message payload (vector number) |
| reg_addr_i | input | 8 | Register byte offset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, one cycle after the read strobe |
| irq_o | output | 1 | Summary interrupt, level |

## Verification
A message or a register write takes effect at the first clock edge after it is driven. The resulting state shows on irq_o in the cycle after that edge. A read's data appears in the cycle after the strobe.

The bench drives every input on the falling edge. It samples irq_o on the next falling edge, after exactly one rising edge has passed. For a read, it raises the strobe on one falling edge and samples reg_rdata_o on the following falling edge. It then drops the strobe and samples again one edge later to confirm that the data returns to zero.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
  typedef enum logic [1:0] {
    REGION_NONE,
    REGION_PEND,
    REGION_EN
  } region_e;
endpackage

// File: rtl/msi_doorbell_dec.sv
module msi_doorbell_dec #(
  parameter int          NUM_VEC  = 256,
  parameter int          DATA_W   = 32,
  parameter logic [63:0] DB_ADDR  = 64'h0000_0040_F000_0100
) (
  input  logic                msg_valid_i,
  input  logic [63:0]         msg_addr_i,
  input  logic [DATA_W-1:0]   msg_data_i,
  output logic [NUM_VEC-1:0]  set_o
);
  logic accept;

  assign accept = msg_valid_i && (msg_addr_i == DB_ADDR) &&
                  (msg_data_i < DATA_W'(NUM_VEC));

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_set
    assign set_o[v] = accept && (msg_data_i == DATA_W'(v));
  end
endmodule

// File: rtl/msi_reg_dec.sv
module msi_reg_dec
  import msi_agg_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int ADDR_W    = 8,
  parameter int PEND_BASE = 'h80,
  parameter int EN_BASE   = 'hA0,
  localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int SPAN = 4 * NUM_WORDS;

  logic [31:0] a;
  logic        aligned, in_pend, in_en;
  logic [31:0] off;

  assign a       = 32'(addr_i);
  assign aligned = (addr_i[1:0] == 2'b00);
  assign in_pend = aligned && (a >= 32'(PEND_BASE)) && (a < 32'(PEND_BASE + SPAN));
  assign in_en   = aligned && (a >= 32'(EN_BASE)) && (a < 32'(EN_BASE + SPAN));

  always_comb begin
    region_o = REGION_NONE;
    off      = '0;
    if (in_pend) begin
      region_o = REGION_PEND;
      off      = a - 32'(PEND_BASE);
    end else if (in_en) begin
      region_o = REGION_EN;
      off      = a - 32'(EN_BASE);
    end
  end

  assign idx_o = IDX_W'(off >> 2);
endmodule

// File: rtl/msi_vec_bank.sv
module msi_vec_bank #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 8,
  parameter bit W1C       = 1'b1,
  localparam int NBITS    = WORD_W * NUM_WORDS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NBITS-1:0]     set_i,
  input  logic [NUM_WORDS-1:0] wr_en_i,
  input  logic [WORD_W-1:0]    wdata_i,
  output logic [NBITS-1:0]     q_o
);
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] q, d, s;
    assign s = set_i[w*WORD_W +: WORD_W];

    if (W1C) begin : g_w1c
      // set applied after clear: a same-cycle set survives
      assign d = (q & ~(wr_en_i[w] ? wdata_i : '0)) | s;
    end else begin : g_rw
      assign d = (wr_en_i[w] ? wdata_i : q) | s;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= d;
    end

    assign q_o[w*WORD_W +: WORD_W] = q;
  end
endmodule

// File: rtl/msi_agg_ctrl.sv
module msi_agg_ctrl
  import msi_agg_pkg::*;
#(
  parameter int          NUM_VEC   = 256,
  parameter int          WORD_W    = 32,
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 8,
  parameter int          PEND_BASE = 'h80,
  parameter int          EN_BASE   = 'hA0,
  parameter logic [63:0] DB_ADDR   = 64'h0000_0040_F000_0100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msg_valid_i,
  input  logic [63:0]       msg_addr_i,
  input  logic [DATA_W-1:0] msg_data_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int NUM_WORDS = NUM_VEC / WORD_W;
  localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  logic [NUM_VEC-1:0]   set_vec;
  logic [NUM_VEC-1:0]   pend_q, en_q;
  logic [NUM_WORDS-1:0] pend_wr, en_wr;
  region_e              region;
  logic [IDX_W-1:0]     idx;
  logic [WORD_W-1:0]    rd_sel, rdata_q;

  msi_doorbell_dec #(
    .NUM_VEC (NUM_VEC),
    .DATA_W  (DATA_W),
    .DB_ADDR (DB_ADDR)
  ) i_db_dec (
    .msg_valid_i (msg_valid_i),
    .msg_addr_i  (msg_addr_i),
    .msg_data_i  (msg_data_i),
    .set_o       (set_vec)
  );

  msi_reg_dec #(
    .NUM_WORDS (NUM_WORDS),
    .ADDR_W    (ADDR_W),
    .PEND_BASE (PEND_BASE),
    .EN_BASE   (EN_BASE)
  ) i_reg_dec (
    .addr_i   (reg_addr_i),
    .region_o (region),
    .idx_o    (idx)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_wr
    assign pend_wr[w] = reg_we_i && (region == REGION_PEND) && (idx == IDX_W'(w));
    assign en_wr[w]   = reg_we_i && (region == REGION_EN)   && (idx == IDX_W'(w));
  end

  msi_vec_bank #(
    .WORD_W    (WORD_W),
    .NUM_WORDS (NUM_WORDS),
    .W1C       (1'b1)
  ) i_pend_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_vec),
    .wr_en_i (pend_wr),
    .wdata_i (reg_wdata_i),
    .q_o     (pend_q)
  );

  msi_vec_bank #(
    .WORD_W    (WORD_W),
    .NUM_WORDS (NUM_WORDS),
    .W1C       (1'b0)
  ) i_en_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   ('0),
    .wr_en_i (en_wr),
    .wdata_i (reg_wdata_i),
    .q_o     (en_q)
  );

  always_comb begin
    unique case (region)
      REGION_PEND: rd_sel = pend_q[idx*WORD_W +: WORD_W];
      REGION_EN:   rd_sel = en_q[idx*WORD_W +: WORD_W];
      default:     rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_re_i) rdata_q <= rd_sel;
    else               rdata_q <= '0;
  end

  assign reg_rdata_o = rdata_q;
  assign irq_o       = |(pend_q & en_q);
endmodule

// File: rtl/msi_agg_sva.sv
module msi_agg_sva #(
  parameter int          NUM_VEC = 256,
  parameter int          WORD_W  = 32,
  parameter int          DATA_W  = 32,
  parameter logic [63:0] DB_ADDR = 64'h0000_0040_F000_0100
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               msg_valid_i,
  input logic [63:0]        msg_addr_i,
  input logic [DATA_W-1:0]  msg_data_i,
  input logic               reg_we_i,
  input logic               reg_re_i,
  input logic [WORD_W-1:0]  reg_rdata_o,
  input logic               irq_o,
  input logic [NUM_VEC-1:0] pend_q,
  input logic [NUM_VEC-1:0] en_q
);
  localparam int VEC_W = $clog2(NUM_VEC);

  logic             acc;
  logic             acc_q, acc_en_q;
  logic [VEC_W-1:0] vec_q;

  assign acc = msg_valid_i && (msg_addr_i == DB_ADDR) &&
               (msg_data_i < DATA_W'(NUM_VEC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= 1'b0;
      acc_en_q <= 1'b0;
      vec_q    <= '0;
    end else begin
      acc_q    <= acc;
      acc_en_q <= acc && !reg_we_i && en_q[msg_data_i[VEC_W-1:0]];
      vec_q    <= msg_data_i[VEC_W-1:0];
    end
  end

  assert_msg_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q |-> pend_q[vec_q]);

  assert_ignored_msg_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc && !reg_we_i) |=> $stable(pend_q));

  assert_en_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> $stable(en_q));

  assert_irq_raised_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_q |-> irq_o);

  assert_irq_masked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !irq_o);

  assert_rdata_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_re_i |=> (reg_rdata_o == '0));
endmodule

bind msi_agg_ctrl msi_agg_sva #(
  .NUM_VEC (NUM_VEC),
  .WORD_W  (WORD_W),
  .DATA_W  (DATA_W),
  .DB_ADDR (DB_ADDR)
) i_msi_agg_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .msg_valid_i (msg_valid_i),
  .msg_addr_i  (msg_addr_i),
  .msg_data_i  (msg_data_i),
  .reg_we_i    (reg_we_i),
  .reg_re_i    (reg_re_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .pend_q      (pend_q),
  .en_q        (en_q)
);

// File: tb/test_msi_agg_ctrl.sv
module test_msi_agg_ctrl;
  localparam int          NV   = 256;
  localparam int          NW   = NV / 32;
  localparam logic [63:0] DB   = 64'h0000_0040_F000_0100;
  localparam logic [7:0]  PEND = 8'h80;
  localparam logic [7:0]  EN   = 8'hA0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 1'b0;
  logic [63:0] msg_addr = '0;
  logic [31:0] msg_data = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] exp_pend [NW];
  logic [31:0] exp_en   [NW];

  always #2 clk = ~clk;

  msi_agg_ctrl i_msi_agg_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .msg_valid_i (msg_valid),
    .msg_addr_i  (msg_addr),
    .msg_data_i  (msg_data),
    .reg_addr_i  (reg_addr),
    .reg_we_i    (reg_we),
    .reg_re_i    (reg_re),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .irq_o       (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_irq();
    logic r = 1'b0;
    for (int w = 0; w < NW; w++) r |= |(exp_pend[w] & exp_en[w]);
    return r;
  endfunction

  task automatic send_msg(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk);
    msg_valid = 1'b1; msg_addr = a; msg_data = d;
    @(negedge clk);
    msg_valid = 1'b0;
    if (a == DB && d < 32'(NV)) exp_pend[d/32][d%32] = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a >= PEND && a < PEND + 8'(4*NW) && a[1:0] == 2'b00)
      exp_pend[(a-PEND)/4] &= ~d;
    else if (a >= EN && a < EN + 8'(4*NW) && a[1:0] == 2'b00)
      exp_en[(a-EN)/4] = d;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    chk(req, reg_rdata, exp);
  endtask

  task automatic rd_all(input string req);
    for (int w = 0; w < NW; w++) begin
      rd(req, PEND + 8'(4*w), exp_pend[w]);
      rd(req, EN + 8'(4*w), exp_en[w]);
    end
  endtask

  task automatic clear_pend();
    for (int w = 0; w < NW; w++) wr(PEND + 8'(4*w), 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < NW; w++) begin exp_pend[w] = '0; exp_en[w] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 rdata", reg_rdata, 32'd0);
    rst_n = 1'b1;
    rd_all("R1");

    // R5: enable words read back, no effect on pending bank
    for (int w = 0; w < NW; w++) wr(EN + 8'(4*w), 32'h1357_9BDF ^ (32'h0101_0101 << w));
    rd_all("R5");
    for (int w = 0; w < NW; w++) wr(EN + 8'(4*w), 32'h0);
    rd_all("R5");

    // R2: every vector latches while disabled; irq stays low (R6)
    for (int n = 0; n < NV; n++) begin
      send_msg(DB, 32'(n));
      chk("R6 masked", 32'(irq), 32'd0);
      rd("R2", PEND + 8'(4*(n/32)), exp_pend[n/32]);
    end

    // R4: partial write-one-to-clear
    for (int w = 0; w < NW; w++) begin
      wr(PEND + 8'(4*w), (32'hA5A5_0F0F << w) | (32'hA5A5_0F0F >> (32-w)));
      rd("R4", PEND + 8'(4*w), exp_pend[w]);
    end
    rd_all("R4");
    clear_pend();
    rd_all("R4");

    // R3: wrong address bits and out-of-range data ignored
    for (int b = 0; b < 64; b++) send_msg(DB ^ (64'd1 << b), 32'(b));
    send_msg(DB, 32'd256);
    send_msg(DB, 32'h8000_0003);
    send_msg(DB, 32'h0001_0010);
    rd_all("R3");

    // R6: irq follows pending AND enable
    for (int n = 0; n < NV; n += 3) begin
      wr(EN + 8'(4*(n/32)), 32'd1 << (n%32));
      chk("R6 idle", 32'(irq), 32'(exp_irq()));
      send_msg(DB, 32'((n + 1) % NV));
      chk("R6 other", 32'(irq), 32'(exp_irq()));
      send_msg(DB, 32'(n));
      chk("R6 raise", 32'(irq), 32'd1);
      wr(EN + 8'(4*(n/32)), 32'd0);
      chk("R6 mask", 32'(irq), 32'd0);
      wr(EN + 8'(4*(n/32)), 32'd1 << (n%32));
      chk("R6 unmask", 32'(irq), 32'd1);
      wr(PEND + 8'(4*(n/32)), 32'd1 << (n%32));
      chk("R6 clear", 32'(irq), 32'(exp_irq()));
      wr(EN + 8'(4*(n/32)), 32'd0);
      clear_pend();
    end

    // R7: same-cycle set and clear
    for (int k = 0; k < 4; k++) begin
      automatic int n = (k == 3) ? 255 : k * 37;
      @(negedge clk);
      msg_valid = 1'b1; msg_addr = DB; msg_data = 32'(n);
      reg_we = 1'b1; reg_addr = PEND + 8'(4*(n/32)); reg_wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      msg_valid = 1'b0; reg_we = 1'b0;
      exp_pend[n/32] = 32'd1 << (n%32);
      rd("R7", PEND + 8'(4*(n/32)), exp_pend[n/32]);
      clear_pend();
    end

    // R9: outside or unaligned offsets
    send_msg(DB, 32'd70);
    wr(EN + 8'h8, 32'hCAFE_F00D);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h7C, 32'hFFFF_FFFF);
    wr(8'hC0, 32'hFFFF_FFFF);
    wr(8'h81, 32'hFFFF_FFFF);
    wr(8'hA2, 32'h0);
    wr(8'hFF, 32'hFFFF_FFFF);
    rd("R9 0x00", 8'h00, 32'd0);
    rd("R9 0x7C", 8'h7C, 32'd0);
    rd("R9 0xC0", 8'hC0, 32'd0);
    rd("R9 0x82", 8'h82, 32'd0);
    rd("R9 0xA9", 8'hA9, 32'd0);
    rd_all("R9");

    // R8: data appears one cycle after strobe and drops with it
    @(negedge clk);
    reg_re = 1'b1; reg_addr = EN + 8'h8;
    chk("R8 before", reg_rdata, 32'd0);
    @(negedge clk);
    reg_re = 1'b0;
    chk("R8 data", reg_rdata, exp_en[2]);
    @(negedge clk);
    chk("R8 idle", reg_rdata, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule